// File: doc/BRIEF.md
# Pipeline Instruction Decoder with Inert Control-Transfer and Memory Opcodes

This combinational block sits in the decode stage of a five-stage integer pipeline. It takes one 32-bit instruction word. From it the block derives every control signal the later stages need: the ALU operation, whether operand B is the immediate or the second register, how the immediate is extended, where a shift amount comes from, which register index receives the result, whether that write happens, and whether the write depends on a conditional-move test.

Arithmetic, logic, shift, conditional-move and upper-immediate instructions are decoded for execution. Jumps, branches, loads and stores are also identified by their opcode, by their function code, or by the rt selector of the branch-on-sign opcode. Their controls are then forced to a harmless form. They request no register write and present a destination index of zero, so any forwarding comparator downstream never matches them. They are flagged on a separate output so a later revision can give them real behaviour without reworking the decode.

Top module: `instr_decoder`

## Requirements
- R1: Opcodes 001001, 001010, 001011, 001100, 001101, 001110 and 001111 (add-immediate unsigned, set-less-than immediate, set-less-than immediate unsigned, and-, or-, xor-immediate, load-upper-immediate) give `src_imm`=1, with destination taken from bits 20:16.
- R2: `alu_op` encodes 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than, 7 unsigned less-than, 8 shift left logical, 9 shift right logical, 10 shift right arithmetic, 11 load-upper (immediate placed in the top half), 12 pass rs. Conditional moves use 12, and every inert instruction gives 0.
- R3: `imm_signed` is 1 for opcodes 001001, 001010 and 001011, and 0 for every other instruction, including the zero-extended logic immediates.
- R4: Opcode 000000 with funct 000000, 000010, 000011, 000100, 000110, 000111, 001010, 001011, 100001, 100011, 100100, 100101, 100110, 100111, 101010 or 101011 gives `src_imm`=0, with destination taken from bits 15:11.
- R5: `shamt_var` is 1 only for the variable shifts (funct 000100, 000110, 000111). The constant shifts (funct 000000, 000010, 000011) and all other instructions give 0.
- R6: `cmov` is 01 for funct 001010 (move if rt equals zero), 10 for funct 001011 (move if rt is nonzero), and 00 otherwise.
- R7: For an executable instruction, `reg_wr` is 1 exactly when the selected destination index is nonzero. A result aimed at register 0 gives `reg_wr`=0.
- R8: Opcodes 000010, 000011, 000100, 000101, 000110, 000111, 100000, 100011, 100100, 101000 and 101011, funct 001000 and 001001 under opcode 000000, and opcode 000001 with bits 20:16 equal to 00000 or 00001 all give `inert`=1, `reg_wr`=0, `dest`=0 and `cmov`=00. Every executable instruction gives `inert`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being decoded |
| alu_op | output | 4 | ALU operation code |
| src_imm | output | 1 | Operand B is the extended immediate |
| imm_signed | output | 1 | Immediate is sign-extended rather than zero-extended |
| shamt_var | output | 1 | Shift amount comes from rs instead of the shamt field |
| cmov | output | 2 | Conditional-move test applied to rt before writing |
| reg_wr | output | 1 | Register-file write request |
| dest | output | 5 | Destination register index, zero when no write |
| inert | output | 1 | Instruction recognised but given no effect |

## Verification
Because the block holds no state, a decode fault shows on the ports in the same cycle the word is applied. There is no later symptom to wait for. The risky faults are an inert instruction that leaks a write or a nonzero destination, and an executable one that picks the wrong register field or extension. Either would silently corrupt a register or mis-steer forwarding. Each listed encoding is therefore driven with its free fields randomised, and every output is compared at once. Destination-zero cases are checked separately.

// File: rtl/instr_decoder.sv
module instr_decoder (
  input  logic [31:0] instr,
  output logic [3:0]  alu_op,
  output logic        src_imm,
  output logic        imm_signed,
  output logic        shamt_var,
  output logic [1:0]  cmov,
  output logic        reg_wr,
  output logic [4:0]  dest,
  output logic        inert
);

  localparam logic [3:0] A_ADD = 4'd0,  A_SUB = 4'd1,  A_AND = 4'd2,  A_OR  = 4'd3,
                         A_XOR = 4'd4,  A_NOR = 4'd5,  A_SLT = 4'd6,  A_SLTU = 4'd7,
                         A_SLL = 4'd8,  A_SRL = 4'd9,  A_SRA = 4'd10, A_LUI = 4'd11,
                         A_PASS = 4'd12;

  localparam logic [5:0] OP_SPEC = 6'b000000, OP_RIMM = 6'b000001,
                         OP_J    = 6'b000010, OP_JAL  = 6'b000011,
                         OP_BEQ  = 6'b000100, OP_BNE  = 6'b000101,
                         OP_BLEZ = 6'b000110, OP_BGTZ = 6'b000111,
                         OP_ADDI = 6'b001001, OP_SLTI = 6'b001010,
                         OP_SLTIU = 6'b001011, OP_ANDI = 6'b001100,
                         OP_ORI  = 6'b001101, OP_XORI = 6'b001110,
                         OP_LUI  = 6'b001111, OP_LB   = 6'b100000,
                         OP_LW   = 6'b100011, OP_LBU  = 6'b100100,
                         OP_SB   = 6'b101000, OP_SW   = 6'b101011;

  localparam logic [5:0] FN_SLL  = 6'b000000, FN_SRL  = 6'b000010,
                         FN_SRA  = 6'b000011, FN_SLLV = 6'b000100,
                         FN_SRLV = 6'b000110, FN_SRAV = 6'b000111,
                         FN_JR   = 6'b001000, FN_JALR = 6'b001001,
                         FN_MOVZ = 6'b001010, FN_MOVN = 6'b001011,
                         FN_ADDU = 6'b100001, FN_SUBU = 6'b100011,
                         FN_AND  = 6'b100100, FN_OR   = 6'b100101,
                         FN_XOR  = 6'b100110, FN_NOR  = 6'b100111,
                         FN_SLT  = 6'b101010, FN_SLTU = 6'b101011;

  localparam logic [4:0] RT_LTZ = 5'b00000, RT_GEZ = 5'b00001;

  wire [5:0] opc = instr[31:26];
  wire [5:0] fn  = instr[5:0];
  wire [4:0] rt  = instr[20:16];
  wire [4:0] rd  = instr[15:11];

  logic wants_wr, use_rd;

  always_comb begin
    alu_op     = A_ADD;
    src_imm    = 1'b0;
    imm_signed = 1'b0;
    shamt_var  = 1'b0;
    cmov       = 2'b00;
    wants_wr   = 1'b0;
    use_rd     = 1'b0;
    inert      = 1'b0;
    unique case (opc)
      OP_SPEC: begin
        use_rd   = 1'b1;
        wants_wr = 1'b1;
        case (fn)
          FN_SLL:  alu_op = A_SLL;
          FN_SRL:  alu_op = A_SRL;
          FN_SRA:  alu_op = A_SRA;
          FN_SLLV: begin alu_op = A_SLL; shamt_var = 1'b1; end
          FN_SRLV: begin alu_op = A_SRL; shamt_var = 1'b1; end
          FN_SRAV: begin alu_op = A_SRA; shamt_var = 1'b1; end
          FN_MOVZ: begin alu_op = A_PASS; cmov = 2'b01; end
          FN_MOVN: begin alu_op = A_PASS; cmov = 2'b10; end
          FN_ADDU: alu_op = A_ADD;
          FN_SUBU: alu_op = A_SUB;
          FN_AND:  alu_op = A_AND;
          FN_OR:   alu_op = A_OR;
          FN_XOR:  alu_op = A_XOR;
          FN_NOR:  alu_op = A_NOR;
          FN_SLT:  alu_op = A_SLT;
          FN_SLTU: alu_op = A_SLTU;
          FN_JR, FN_JALR: begin
            wants_wr = 1'b0;
            inert    = 1'b1;
          end
          default: wants_wr = 1'b0;
        endcase
      end
      OP_RIMM:
        inert = (rt == RT_LTZ) || (rt == RT_GEZ);
      OP_ADDI:  begin src_imm = 1'b1; imm_signed = 1'b1; wants_wr = 1'b1; alu_op = A_ADD;  end
      OP_SLTI:  begin src_imm = 1'b1; imm_signed = 1'b1; wants_wr = 1'b1; alu_op = A_SLT;  end
      OP_SLTIU: begin src_imm = 1'b1; imm_signed = 1'b1; wants_wr = 1'b1; alu_op = A_SLTU; end
      OP_ANDI:  begin src_imm = 1'b1; wants_wr = 1'b1; alu_op = A_AND; end
      OP_ORI:   begin src_imm = 1'b1; wants_wr = 1'b1; alu_op = A_OR;  end
      OP_XORI:  begin src_imm = 1'b1; wants_wr = 1'b1; alu_op = A_XOR; end
      OP_LUI:   begin src_imm = 1'b1; wants_wr = 1'b1; alu_op = A_LUI; end
      OP_J, OP_JAL, OP_BEQ, OP_BNE, OP_BLEZ, OP_BGTZ,
      OP_LB, OP_LW, OP_LBU, OP_SB, OP_SW:
        inert = 1'b1;
      default: ;
    endcase
  end

  wire [4:0] target = use_rd ? rd : rt;

  assign reg_wr = wants_wr && (target != 5'd0);
  assign dest   = wants_wr ? target : 5'd0;

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr,
  input logic [3:0]  alu_op,
  input logic        src_imm,
  input logic        imm_signed,
  input logic        shamt_var,
  input logic [1:0]  cmov,
  input logic        reg_wr,
  input logic [4:0]  dest,
  input logic        inert
);

  always_comb begin
    if (!$isunknown(instr)) begin
      assert_imm_dest_R1: assert (!(src_imm && reg_wr) || dest == instr[20:16])
        else $error("R1 immediate op writes a field other than rt");
      assert_pass_for_cmov_R2: assert (cmov == 2'b00 || alu_op == 4'd12)
        else $error("R2 conditional move without pass-rs ALU code");
      assert_signed_needs_imm_R3: assert (!imm_signed || src_imm)
        else $error("R3 sign extension flagged for register operand");
      assert_reg_dest_R4: assert (!(!src_imm && reg_wr) || dest == instr[15:11])
        else $error("R4 register op writes a field other than rd");
      assert_var_shift_R5: assert (!shamt_var || (alu_op >= 4'd8 && alu_op <= 4'd10 && !src_imm))
        else $error("R5 variable shift source on a non-shift op");
      assert_cmov_code_R6: assert (cmov != 2'b11)
        else $error("R6 illegal conditional-move code");
      assert_no_zero_write_R7: assert (!reg_wr || dest != 5'd0)
        else $error("R7 write request aimed at register zero");
      assert_inert_quiet_R8: assert (!inert || (!reg_wr && dest == 5'd0 && cmov == 2'b00))
        else $error("R8 inert instruction leaks an effect");
    end
  end

endmodule

bind instr_decoder instr_decoder_chk chk (
  .instr(instr), .alu_op(alu_op), .src_imm(src_imm), .imm_signed(imm_signed),
  .shamt_var(shamt_var), .cmov(cmov), .reg_wr(reg_wr), .dest(dest), .inert(inert)
);

// File: tb/instr_decoder_test.sv
module instr_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr;
  logic [3:0]  alu_op;
  logic        src_imm, imm_signed, shamt_var, reg_wr, inert;
  logic [1:0]  cmov;
  logic [4:0]  dest;

  instr_decoder uut (
    .instr(instr), .alu_op(alu_op), .src_imm(src_imm), .imm_signed(imm_signed),
    .shamt_var(shamt_var), .cmov(cmov), .reg_wr(reg_wr), .dest(dest), .inert(inert)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [3:0] alu;
    logic       imm;
    logic       sgn;
    logic       var_sh;
    logic [1:0] cm;
    logic       wr;
    logic [4:0] dst;
    logic       nop;
  } exp_t;

  localparam int KINDS = 38;

  function automatic logic [31:0] make_instr(int k, logic [31:0] r);
    logic [5:0] op;
    logic [5:0] fn;
    op = 6'd0; fn = 6'd0;
    if (k < 7) begin
      op = 6'(9 + k);
      return {op, r[25:0]};
    end else if (k < 25) begin
      case (k)
        7: fn = 6'd0;   8: fn = 6'd2;   9: fn = 6'd3;   10: fn = 6'd4;
        11: fn = 6'd6;  12: fn = 6'd7;  13: fn = 6'd10; 14: fn = 6'd11;
        15: fn = 6'd33; 16: fn = 6'd35; 17: fn = 6'd36; 18: fn = 6'd37;
        19: fn = 6'd38; 20: fn = 6'd39; 21: fn = 6'd42; 22: fn = 6'd43;
        23: fn = 6'd8;  default: fn = 6'd9;
      endcase
      return {6'd0, r[25:6], fn};
    end else if (k < 31) begin
      op = 6'(k - 23);
      return {op, r[25:0]};
    end else if (k < 33) begin
      return {6'd1, r[25:21], 5'(k - 31), r[15:0]};
    end else begin
      case (k)
        33: op = 6'd32; 34: op = 6'd35; 35: op = 6'd36; 36: op = 6'd40;
        default: op = 6'd43;
      endcase
      return {op, r[25:0]};
    end
  endfunction

  function automatic exp_t expect_of(logic [31:0] w);
    exp_t e;
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [4:0] idx = 5'd0;
    logic exec = 1'b0;
    e = '0;
    if (op >= 6'd9 && op <= 6'd15) begin
      exec = 1'b1; e.imm = 1'b1; idx = w[20:16];
      e.sgn = (op <= 6'd11);
      case (op)
        6'd9: e.alu = 4'd0;  6'd10: e.alu = 4'd6; 6'd11: e.alu = 4'd7;
        6'd12: e.alu = 4'd2; 6'd13: e.alu = 4'd3; 6'd14: e.alu = 4'd4;
        default: e.alu = 4'd11;
      endcase
    end else if (op == 6'd0 && fn != 6'd8 && fn != 6'd9) begin
      exec = 1'b1; idx = w[15:11];
      case (fn)
        6'd0: e.alu = 4'd8;  6'd2: e.alu = 4'd9;  6'd3: e.alu = 4'd10;
        6'd4: begin e.alu = 4'd8;  e.var_sh = 1'b1; end
        6'd6: begin e.alu = 4'd9;  e.var_sh = 1'b1; end
        6'd7: begin e.alu = 4'd10; e.var_sh = 1'b1; end
        6'd10: begin e.alu = 4'd12; e.cm = 2'b01; end
        6'd11: begin e.alu = 4'd12; e.cm = 2'b10; end
        6'd33: e.alu = 4'd0; 6'd35: e.alu = 4'd1; 6'd36: e.alu = 4'd2;
        6'd37: e.alu = 4'd3; 6'd38: e.alu = 4'd4; 6'd39: e.alu = 4'd5;
        6'd42: e.alu = 4'd6; default: e.alu = 4'd7;
      endcase
    end else begin
      e.nop = 1'b1;
    end
    if (exec) begin
      e.wr  = (idx != 5'd0);
      e.dst = idx;
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] w, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s instr=%08h actual=%0d expected=%0d", req, w, act, exp);
    end
  endtask

  task automatic apply_and_check(logic [31:0] w);
    exp_t e;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    e = expect_of(w);
    check(alu_op == e.alu, "R2 alu_op", w, alu_op, e.alu);
    check(src_imm == e.imm, e.imm ? "R1 src_imm" : "R4 src_imm", w, src_imm, e.imm);
    check(imm_signed == e.sgn, "R3 imm_signed", w, imm_signed, e.sgn);
    check(shamt_var == e.var_sh, "R5 shamt_var", w, shamt_var, e.var_sh);
    check(cmov == e.cm, "R6 cmov", w, cmov, e.cm);
    check(reg_wr == e.wr, e.nop ? "R8 reg_wr" : "R7 reg_wr", w, reg_wr, e.wr);
    check(dest == e.dst, e.nop ? "R8 dest" : (e.imm ? "R1 dest" : "R4 dest"), w, dest, e.dst);
    check(inert == e.nop, "R8 inert", w, inert, e.nop);
  endtask

  initial begin
    void'($urandom(32'd1947));
    instr = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero word is a shift into register 0, so R7 forbids the write
    check(reg_wr == 1'b0 && dest == 5'd0 && inert == 1'b0, "R7 reset nop", instr, reg_wr, 0);

    // every listed encoding, several random fillers each
    for (int k = 0; k < KINDS; k++)
      for (int j = 0; j < 4; j++)
        apply_and_check(make_instr(k, $urandom()));

    // R7 corner: destination zero on both formats and on a conditional move
    apply_and_check({6'd0, 5'd3, 5'd4, 5'd0, 5'd0, 6'd33});
    apply_and_check({6'd9, 5'd3, 5'd0, 16'hffff});
    apply_and_check({6'd0, 5'd7, 5'd8, 5'd0, 5'd0, 6'd11});
    // R1/R4 corner: rt and rd equal 31 and differ from each other
    apply_and_check({6'd13, 5'd1, 5'd31, 5'd2, 5'd0, 6'd0});
    apply_and_check({6'd0, 5'd1, 5'd2, 5'd31, 5'd5, 6'd42});
    // R8 corner: inert ops whose rt/rd fields are nonzero must not leak them
    apply_and_check({6'd0, 5'd31, 5'd0, 5'd31, 5'd0, 6'd9});
    apply_and_check({6'd35, 5'd29, 5'd12, 16'h8000});
    apply_and_check({6'd1, 5'd4, 5'd1, 16'h0010});

    for (int i = 0; i < 3000; i++)
      apply_and_check(make_instr(int'($urandom_range(KINDS - 1, 0)), $urandom()));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule